// File: doc/BRIEF.md
# Supply Voltage Monitor Status and Interrupt Controller

This block sits between an analog comparator and the interrupt fabric. It holds a small control register whose fields pick one of four comparator thresholds: three supply levels, plus a fixed reference for an external sense pin. The same register chooses which transition of the monitored level raises an event, and carries an active-low interrupt mask. The selected threshold code is driven out to the analog side. The comparator's raw output comes back asynchronously and is passed through a synchroniser. The synchronised value becomes a status bit that reads 1 when the monitored voltage is above the threshold and 0 when it is below.

A transition of the status bit in the selected direction sets a sticky pending flag. The pending flag stays set until it is acknowledged. The interrupt line (line 7 of the system interrupt map) is asserted whenever the flag is pending and the mask bit is 0. Any write to the control register opens a short blanking window. While the window is open, status transitions are not treated as events, so that moving the threshold cannot raise a false interrupt.

Top module: `vmon_irq_ctrl`

## Requirements
- R1: After reset, `thr_sel` is 0, `cfg_rdata` is 4'b1000 (mask set, rising edge selected, lowest supply threshold), and `above_thr`, `irq_pend` and `irq7` are 0.
- R2: `above_thr` equals the value `cmp_raw` held before the second rising clock edge after `cmp_raw` changes (two-stage synchroniser).
- R3: `thr_sel` equals `cfg_rdata[1:0]`. The codes are: 0 = 2.2 V supply, 1 = 2.6 V supply, 2 = 3.0 V supply, 3 = external pin against 1.3 V.
- R4: With `cfg_rdata[2]` = 0 (rising mode), a 0-to-1 change of `above_thr` sets `irq_pend` on the next clock edge, which is three edges after `cmp_raw` changes. A 1-to-0 change sets nothing.
- R5: With `cfg_rdata[2]` = 1 (falling mode), a 1-to-0 change of `above_thr` sets `irq_pend` three edges after `cmp_raw` changes. A 0-to-1 change sets nothing.
- R6: `irq_pend` stays set until a clock edge sampling `irq_ack` = 1 clears it. If a new event and an acknowledge meet on the same edge, the flag stays set.
- R7: `irq7` is a register that is 1 exactly when `irq_pend` is 1 and mask bit `cfg_rdata[3]` is 0. It follows the same edge that changes either of them.
- R8: With the mask bit at 1, events still set `irq_pend`, but `irq7` stays 0.
- R9: A transition that reaches `above_thr` on the write edge of the control register, or on the edge after it, sets no pending flag.
- R10: A write of `cfg_wdata` with `cfg_wr` = 1 appears on `cfg_rdata` after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous comparator output, 1 = above threshold |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Write data: [3] mask, [2] falling-edge select, [1:0] threshold code |
| irq_ack | input | 1 | Write-one-to-clear of the pending flag |
| thr_sel | output | 2 | Threshold code driven to the comparator |
| cfg_rdata | output | 4 | Control register contents |
| above_thr | output | 1 | Synchronised status bit |
| irq_pend | output | 1 | Sticky pending flag |
| irq7 | output | 1 | Interrupt request line 7 |

## Verification
A change on `cmp_raw` reaches `above_thr` after two rising edges and reaches `irq_pend` and `irq7` after three. A control register write shows on `cfg_rdata`, `thr_sel` and `irq7` after one edge, as does an acknowledge on `irq_pend`. The bench drives every input on a falling edge and counts exactly that many falling edges before it samples. It also checks one edge early where the timing matters, such as for the status bit and the falling-mode event. The blanking case changes the comparator one edge before a register write, so the status change lands inside the window. The bench then confirms that no flag appears. A later unblanked transition confirms that the same stimulus does set the flag.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
  localparam int CFG_W = 4;

  typedef enum logic [1:0] {
    THR_SUP_LOW  = 2'd0,
    THR_SUP_MID  = 2'd1,
    THR_SUP_HIGH = 2'd2,
    THR_EXT_PIN  = 2'd3
  } thr_code_e;

  typedef struct packed {
    logic      mask;
    logic      fall_sel;
    thr_code_e thr;
  } vmon_cfg_t;

  localparam vmon_cfg_t CFG_RESET = '{mask: 1'b1, fall_sel: 1'b0, thr: THR_SUP_LOW};
endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/vmon_cfg.sv
module vmon_cfg
  import vmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output vmon_cfg_t        cfg_q,
  output vmon_cfg_t        cfg_nxt
);
  always_comb begin
    cfg_nxt = cfg_q;
    if (wr) cfg_nxt = vmon_cfg_t'(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_RESET;
    else     cfg_q <= cfg_nxt;
  end

  assert_cfg_load_R10: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cfg_q == vmon_cfg_t'($past(wdata))));
endmodule

// File: rtl/vmon_edge.sv
module vmon_edge #(
  parameter int BLANK_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic fall_sel,
  input  logic restart,
  output logic evt
);
  localparam int CNT_W = $clog2(BLANK_CYC + 1);

  logic             prev_q;
  logic [CNT_W-1:0] blank_q;
  logic             rise_w, fall_w;

  assign rise_w = level & ~prev_q;
  assign fall_w = prev_q & ~level;
  assign evt    = (fall_sel ? fall_w : rise_w) & (blank_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      blank_q <= '0;
    end else begin
      prev_q <= level;
      if (restart)             blank_q <= CNT_W'(BLANK_CYC);
      else if (blank_q != '0)  blank_q <= blank_q - 1'b1;
    end
  end

  assert_blank_load_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (blank_q == CNT_W'(BLANK_CYC)));
endmodule

// File: rtl/vmon_irq_ctrl.sv
module vmon_irq_ctrl
  import vmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BLANK_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_raw,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             irq_ack,
  output logic [1:0]       thr_sel,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             above_thr,
  output logic             irq_pend,
  output logic             irq7
);
  vmon_cfg_t cfg_q, cfg_nxt;
  logic      lvl_sync;
  logic      evt;
  logic      pend_nxt;

  vmon_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_wr),
    .wdata   (cfg_wdata),
    .cfg_q   (cfg_q),
    .cfg_nxt (cfg_nxt)
  );

  vmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_raw),
    .q   (lvl_sync)
  );

  vmon_edge #(.BLANK_CYC(BLANK_CYC)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .level    (lvl_sync),
    .fall_sel (cfg_q.fall_sel),
    .restart  (cfg_wr),
    .evt      (evt)
  );

  assign pend_nxt = evt | (irq_pend & ~irq_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend <= 1'b0;
      irq7     <= 1'b0;
    end else begin
      irq_pend <= pend_nxt;
      irq7     <= pend_nxt & ~cfg_nxt.mask;
    end
  end

  assign above_thr = lvl_sync;
  assign thr_sel   = cfg_q.thr;
  assign cfg_rdata = cfg_q;

  assert_irq_needs_pend_R7: assert property (@(posedge clk) disable iff (rst)
    irq7 |-> (irq_pend && !cfg_q.mask));
  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && !irq_ack) |=> irq_pend);
  assert_no_evt_after_wr_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !evt);
  assert_pend_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pend) |-> $past(evt));
endmodule

// File: tb/vmon_irq_ctrl_tb.sv
module vmon_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_raw = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic       irq_ack = 1'b0;
  logic [1:0] thr_sel;
  logic [3:0] cfg_rdata;
  logic       above_thr, irq_pend, irq7;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vmon_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .thr_sel(thr_sel),
    .cfg_rdata(cfg_rdata), .above_thr(above_thr), .irq_pend(irq_pend),
    .irq7(irq7)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 thr_sel", thr_sel, 0);
    check("R1 cfg_rdata", cfg_rdata, 8);
    check("R1 above_thr", above_thr, 0);
    check("R1 irq_pend", irq_pend, 0);
    check("R1 irq7", irq7, 0);
  endtask

  task automatic t_rise_masked();
    cmp_raw = 1'b1;
    tick(1); check("R2 status one edge", above_thr, 0);
    tick(1); check("R2 status two edges", above_thr, 1);
    check("R4 pend not yet", irq_pend, 0);
    tick(1); check("R4 rising sets pend", irq_pend, 1);
    check("R8 masked irq low", irq7, 0);
    cmp_raw = 1'b0;
    tick(4); check("R6 sticky pend", irq_pend, 1);
    check("R2 status back low", above_thr, 0);
  endtask

  task automatic t_unmask_ack();
    write_cfg(4'b0000);
    check("R7 unmask raises irq", irq7, 1);
    ack();
    check("R6 ack clears pend", irq_pend, 0);
    check("R7 irq drops with pend", irq7, 0);
  endtask

  task automatic t_thr();
    for (int c = 0; c < 4; c++) begin
      write_cfg(4'(c));
      check("R3 thr_sel", thr_sel, c);
      check("R10 readback", cfg_rdata, c);
    end
    tick(3);
    check("R9 writes alone no pend", irq_pend, 0);
  endtask

  task automatic t_fall();
    write_cfg(4'b0111);
    check("R10 readback fall", cfg_rdata, 7);
    tick(3);
    cmp_raw = 1'b1;
    tick(5); check("R5 rising ignored", irq_pend, 0);
    cmp_raw = 1'b0;
    tick(2); check("R5 pend not yet", irq_pend, 0);
    tick(1); check("R5 falling sets pend", irq_pend, 1);
    check("R7 irq with pend", irq7, 1);
    ack();
    check("R6 ack after fall", irq_pend, 0);
  endtask

  task automatic t_ack_race();
    cmp_raw = 1'b1;
    tick(4);
    cmp_raw = 1'b0;
    tick(2);
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    check("R6 set wins over ack", irq_pend, 1);
    ack();
    check("R6 ack clears", irq_pend, 0);
  endtask

  task automatic t_blank();
    write_cfg(4'b0011);
    tick(3);
    cmp_raw = 1'b1;
    tick(1);
    write_cfg(4'b0011);
    tick(4);
    check("R9 blanked rise", irq_pend, 0);
    check("R9 blanked irq", irq7, 0);
    cmp_raw = 1'b0;
    tick(4);
    cmp_raw = 1'b1;
    tick(3);
    check("R4 unblanked rise", irq_pend, 1);
    ack();
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_rise_masked();
    t_unmask_ack();
    t_thr();
    t_fall();
    t_ack_race();
    t_blank();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule